// File: doc/BRIEF.md
# Network Controller Power-State and Wake Controller

This block keeps the power state of a bus-attached network controller and drives the signals that follow from it. It has four modes: an unconfigured D0 mode, a configured D0 mode, D3, and a deeper power-down mode. The two D0 modes exclude each other. Which one applies depends on the programmable field of the base address. A board strap can also pin the block to the configured mode. From D3 the block drops into power-down on its own once the bus PME line is released.

The block also holds the wake registers. When a link change or a magic packet arrives and that source is enabled, the block latches an event bit and a PME status bit. It requests PME while PME is enabled. The outputs go to the PHY power-down pin, the clock gates for the core, transmit and receive clocks, the LED drivers, and an unconfigured indication toward the PHY. Every one of these outputs comes straight from a flop.

Top module: `pwr_wake_ctl`

## Requirements
- R1: After reset the block is in the unconfigured D0 mode. phy_pd_o=1, all three clock enables are 0, led_off_o=1 and uninit_o=1. Both read words are zero and pme_req_o=0.
- R2: A base-address write with a nonzero field selects the configured D0 mode: phy_pd_o=0, all clocks enabled, led_off_o=0 and uninit_o=0. A write with a zero field returns the block to the unconfigured mode.
- R3: While force_cfg_i=1, a block in D0 is in the configured mode whatever the base-address field holds.
- R4: A magic_pkt_i pulse with the magic enable set (wake word bit 1) sets the magic event bit (wake word bit 3) and PME status (control bit 15). With the enable clear, the pulse changes nothing.
- R5: A link_chg_i pulse with the link enable set (wake word bit 0) sets the link event bit (bit 2), clears the link enable and sets PME status. A later link change therefore has no effect.
- R6: pme_req_o is high only while both PME status and PME enable (control bit 8) are set. Writing PME enable to 0 drops pme_req_o on the cycle after the write, and PME status is kept.
- R7: PME status and the two event bits clear only when a 1 is written to them. Writing 0 to those positions leaves them unchanged.
- R8: Writing power-state field 2'b11 (control bits 1:0) from D0 enters D3, where the PHY and clocks stay on. In D3, a cycle with pme_line_i=0 moves the block to power-down: phy_pd_o=1, clocks off, LEDs off. The control word reads state 2'b11 in both D3 and power-down.
- R9: Writing field 2'b00 from D3 or power-down returns the block to D0 and clears the stored base-address configuration, so the block comes back unconfigured.
- R10: While wake is armed (PME enable set and any wake enable set), the unconfigured and power-down modes keep the PHY powered and the core and receive clocks running, and hold uninit_o=0. The transmit clock stays gated.
- R11: Power-state field values 2'b01 and 2'b10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, never gated |
| rst_n | input | 1 | Active-low asynchronous reset |
| pmc_wr_i | input | 1 | Write strobe for the power-control word |
| pmc_wdata_i | input | 16 | Control write data: [1:0] state, [8] PME enable, [15] PME status (W1C) |
| wev_wr_i | input | 1 | Write strobe for the wake word |
| wev_wdata_i | input | 4 | Wake write data: [0] link enable, [1] magic enable, [2] link event W1C, [3] magic event W1C |
| bar_wr_i | input | 1 | Base-address write strobe |
| bar_field_i | input | BAR_W | Programmable field of the base address being written |
| force_cfg_i | input | 1 | Strap that forces the configured D0 mode |
| pme_line_i | input | 1 | Sampled PME line, 1 = asserted on the bus |
| link_chg_i | input | 1 | Link-change pulse |
| magic_pkt_i | input | 1 | Magic-packet pulse |
| pme_req_o | output | 1 | PME request |
| phy_pd_o | output | 1 | PHY power-down |
| core_clk_en_o | output | 1 | Core clock gate enable |
| tx_clk_en_o | output | 1 | Transmit clock gate enable |
| rx_clk_en_o | output | 1 | Receive clock gate enable |
| led_off_o | output | 1 | Forces the LED drivers off |
| uninit_o | output | 1 | Unconfigured indication toward the PHY |
| pmc_rdata_o | output | 16 | Control word read value |
| wev_rdata_o | output | 4 | Wake word read value |

## Verification
The bench sends a second link change after the first one has already disarmed its enable. A design that forgot to clear the enable would raise a second event. It writes zeros to the W1C positions, where a plain read-write register would lose its status. It clears PME enable while status is pending, and a design that tied status to the request would lose the status. It also leaves D3 after a nonzero base write, and a design that kept the configuration would come back in the configured mode. Further cases are the forced strap against a zero base write, the reserved state codes, and wake arming in power-down. In that last case a design would power the PHY off and miss the magic packet.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
    typedef enum logic [1:0] {
        PM_D0U = 2'd0,
        PM_D0I = 2'd1,
        PM_D3  = 2'd2,
        PM_PDN = 2'd3
    } pm_mode_e;

    localparam int          PMC_W       = 16;
    localparam int          WEV_W       = 4;
    localparam int          PMC_EN_BIT  = 8;
    localparam int          PMC_ST_BIT  = 15;
    localparam logic [1:0]  PS_D0       = 2'b00;
    localparam logic [1:0]  PS_D3       = 2'b11;
    localparam int          WEV_LEN_BIT = 0;
    localparam int          WEV_MEN_BIT = 1;
    localparam int          WEV_LEV_BIT = 2;
    localparam int          WEV_MEV_BIT = 3;
endpackage

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import pwr_wake_pkg::*;
#(
    parameter int BAR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ps_wr_i,
    input  logic [1:0]       ps_val_i,
    input  logic             bar_wr_i,
    input  logic [BAR_W-1:0] bar_field_i,
    input  logic             force_cfg_i,
    input  logic             pme_line_i,
    output pm_mode_e         mode_q_o,
    output pm_mode_e         mode_d_o
);
    typedef struct packed {
        pm_mode_e mode;
        logic     bar_nz;
    } fsm_t;

    fsm_t st_d, st_q;
    logic in_d0;

    always_comb begin
        st_d  = st_q;
        in_d0 = (st_q.mode == PM_D0U) || (st_q.mode == PM_D0I);
        if (bar_wr_i) begin
            st_d.bar_nz = |bar_field_i;
        end
        if (ps_wr_i && ps_val_i == PS_D3 && in_d0) begin
            st_d.mode = PM_D3;
        end else if (ps_wr_i && ps_val_i == PS_D0 && !in_d0) begin
            st_d.mode   = PM_D0U;
            st_d.bar_nz = 1'b0;
        end else if (st_q.mode == PM_D3 && !pme_line_i) begin
            st_d.mode = PM_PDN;
        end
        if (st_d.mode == PM_D0U || st_d.mode == PM_D0I) begin
            st_d.mode = (force_cfg_i || st_d.bar_nz) ? PM_D0I : PM_D0U;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: PM_D0U, bar_nz: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q_o = st_q.mode;
    assign mode_d_o = st_d.mode;
endmodule

// File: rtl/pm_wake_regs.sv
module pm_wake_regs
    import pwr_wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pmc_wr_i,
    input  logic [PMC_W-1:0] pmc_wdata_i,
    input  logic             wev_wr_i,
    input  logic [WEV_W-1:0] wev_wdata_i,
    input  logic             link_chg_i,
    input  logic             magic_pkt_i,
    output logic             pme_en_o,
    output logic             pme_st_o,
    output logic [WEV_W-1:0] wev_o,
    output logic             wol_d_o
);
    typedef struct packed {
        logic pme_en;
        logic pme_st;
        logic [WEV_W-1:0] wev;
    } wake_t;

    wake_t wk_d, wk_q;

    always_comb begin
        wk_d = wk_q;
        if (pmc_wr_i) begin
            wk_d.pme_en = pmc_wdata_i[PMC_EN_BIT];
            if (pmc_wdata_i[PMC_ST_BIT]) wk_d.pme_st = 1'b0;
        end
        if (wev_wr_i) begin
            wk_d.wev[WEV_LEN_BIT] = wev_wdata_i[WEV_LEN_BIT];
            wk_d.wev[WEV_MEN_BIT] = wev_wdata_i[WEV_MEN_BIT];
            if (wev_wdata_i[WEV_LEV_BIT]) wk_d.wev[WEV_LEV_BIT] = 1'b0;
            if (wev_wdata_i[WEV_MEV_BIT]) wk_d.wev[WEV_MEV_BIT] = 1'b0;
        end
        if (link_chg_i && wk_q.wev[WEV_LEN_BIT]) begin
            wk_d.wev[WEV_LEV_BIT] = 1'b1;
            wk_d.wev[WEV_LEN_BIT] = 1'b0;
            wk_d.pme_st           = 1'b1;
        end
        if (magic_pkt_i && wk_q.wev[WEV_MEN_BIT]) begin
            wk_d.wev[WEV_MEV_BIT] = 1'b1;
            wk_d.pme_st           = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q <= '0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign pme_en_o = wk_q.pme_en;
    assign pme_st_o = wk_q.pme_st;
    assign wev_o    = wk_q.wev;
    assign wol_d_o  = wk_d.pme_en && (wk_d.wev[WEV_LEN_BIT] || wk_d.wev[WEV_MEN_BIT]);
endmodule

// File: rtl/pm_clk_gate.sv
module pm_clk_gate
    import pwr_wake_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pm_mode_e mode_d_i,
    input  logic     wol_d_i,
    output logic     phy_pd_o,
    output logic     core_en_o,
    output logic     tx_en_o,
    output logic     rx_en_o,
    output logic     led_off_o,
    output logic     uninit_o
);
    typedef struct packed {
        logic phy_pd;
        logic core_en;
        logic tx_en;
        logic rx_en;
        logic led_off;
        logic uninit;
    } gate_t;

    localparam gate_t GATE_RST = '{phy_pd: 1'b1, core_en: 1'b0, tx_en: 1'b0,
                                   rx_en: 1'b0, led_off: 1'b1, uninit: 1'b1};

    gate_t g_d, g_q;
    logic  low_pwr;
    logic  hard_off;

    always_comb begin
        low_pwr   = (mode_d_i == PM_D0U) || (mode_d_i == PM_PDN);
        hard_off  = low_pwr && !wol_d_i;
        g_d.phy_pd  = hard_off;
        g_d.core_en = !hard_off;
        g_d.rx_en   = !hard_off;
        g_d.tx_en   = !low_pwr;
        g_d.led_off = low_pwr;
        g_d.uninit  = (mode_d_i == PM_D0U) && !wol_d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= GATE_RST;
        end else begin
            g_q <= g_d;
        end
    end

    assign phy_pd_o  = g_q.phy_pd;
    assign core_en_o = g_q.core_en;
    assign tx_en_o   = g_q.tx_en;
    assign rx_en_o   = g_q.rx_en;
    assign led_off_o = g_q.led_off;
    assign uninit_o  = g_q.uninit;
endmodule

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl
    import pwr_wake_pkg::*;
#(
    parameter int BAR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pmc_wr_i,
    input  logic [15:0]      pmc_wdata_i,
    input  logic             wev_wr_i,
    input  logic [3:0]       wev_wdata_i,
    input  logic             bar_wr_i,
    input  logic [BAR_W-1:0] bar_field_i,
    input  logic             force_cfg_i,
    input  logic             pme_line_i,
    input  logic             link_chg_i,
    input  logic             magic_pkt_i,
    output logic             pme_req_o,
    output logic             phy_pd_o,
    output logic             core_clk_en_o,
    output logic             tx_clk_en_o,
    output logic             rx_clk_en_o,
    output logic             led_off_o,
    output logic             uninit_o,
    output logic [15:0]      pmc_rdata_o,
    output logic [3:0]       wev_rdata_o
);
    pm_mode_e mode_q, mode_d;
    logic     pme_en, pme_st, wol_d;
    logic     in_d3;

    pm_state_fsm #(.BAR_W(BAR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ps_wr_i     (pmc_wr_i),
        .ps_val_i    (pmc_wdata_i[1:0]),
        .bar_wr_i    (bar_wr_i),
        .bar_field_i (bar_field_i),
        .force_cfg_i (force_cfg_i),
        .pme_line_i  (pme_line_i),
        .mode_q_o    (mode_q),
        .mode_d_o    (mode_d)
    );

    pm_wake_regs u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .pmc_wr_i    (pmc_wr_i),
        .pmc_wdata_i (pmc_wdata_i),
        .wev_wr_i    (wev_wr_i),
        .wev_wdata_i (wev_wdata_i),
        .link_chg_i  (link_chg_i),
        .magic_pkt_i (magic_pkt_i),
        .pme_en_o    (pme_en),
        .pme_st_o    (pme_st),
        .wev_o       (wev_rdata_o),
        .wol_d_o     (wol_d)
    );

    pm_clk_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_d_i  (mode_d),
        .wol_d_i   (wol_d),
        .phy_pd_o  (phy_pd_o),
        .core_en_o (core_clk_en_o),
        .tx_en_o   (tx_clk_en_o),
        .rx_en_o   (rx_clk_en_o),
        .led_off_o (led_off_o),
        .uninit_o  (uninit_o)
    );

    assign in_d3       = (mode_q == PM_D3) || (mode_q == PM_PDN);
    assign pme_req_o   = pme_st && pme_en;
    assign pmc_rdata_o = {pme_st, 6'b0, pme_en, 6'b0, in_d3 ? PS_D3 : PS_D0};
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pmc_wr_i,
    input logic [15:0] pmc_wdata_i,
    input logic        wev_wr_i,
    input logic [3:0]  wev_wdata_i,
    input logic        force_cfg_i,
    input logic        pme_line_i,
    input logic        link_chg_i,
    input logic        magic_pkt_i,
    input logic        pme_req_o,
    input logic        phy_pd_o,
    input logic        core_clk_en_o,
    input logic        led_off_o,
    input logic [15:0] pmc_rdata_o,
    input logic [3:0]  wev_rdata_o
);
    assert_force_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        force_cfg_i && !pmc_wr_i && pmc_rdata_o[1:0] == 2'b00 |=> !led_off_o);

    assert_link_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        link_chg_i && wev_rdata_o[0] |=> wev_rdata_o[2] && !wev_rdata_o[0]);

    assert_pme_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pmc_wr_i && !pmc_wdata_i[8] |=> !pme_req_o);

    assert_w1c_magic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wev_wr_i && wev_wdata_i[3] && !magic_pkt_i |=> !wev_rdata_o[3]);

    assert_pdn_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pmc_rdata_o[1:0] == 2'b11 && !pme_line_i && !pmc_wr_i && !pmc_rdata_o[8]
        |=> phy_pd_o && !core_clk_en_o);
endmodule

bind pwr_wake_ctl pwr_wake_chk u_chk (.*);

// File: tb/pwr_wake_ctl_test.sv
module pwr_wake_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int BAR_W      = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pmc_wr = 1'b0;
    logic [15:0]      pmc_wdata = '0;
    logic             wev_wr = 1'b0;
    logic [3:0]       wev_wdata = '0;
    logic             bar_wr = 1'b0;
    logic [BAR_W-1:0] bar_field = '0;
    logic             force_cfg = 1'b0;
    logic             pme_line = 1'b1;
    logic             link_chg = 1'b0;
    logic             magic_pkt = 1'b0;
    logic             pme_req, phy_pd, core_en, tx_en, rx_en, led_off, uninit;
    logic [15:0]      pmc_rdata;
    logic [3:0]       wev_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_wake_ctl #(.BAR_W(BAR_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .pmc_wr_i(pmc_wr), .pmc_wdata_i(pmc_wdata),
        .wev_wr_i(wev_wr), .wev_wdata_i(wev_wdata),
        .bar_wr_i(bar_wr), .bar_field_i(bar_field),
        .force_cfg_i(force_cfg), .pme_line_i(pme_line),
        .link_chg_i(link_chg), .magic_pkt_i(magic_pkt),
        .pme_req_o(pme_req), .phy_pd_o(phy_pd), .core_clk_en_o(core_en),
        .tx_clk_en_o(tx_en), .rx_clk_en_o(rx_en), .led_off_o(led_off),
        .uninit_o(uninit), .pmc_rdata_o(pmc_rdata), .wev_rdata_o(wev_rdata)
    );

    typedef struct {
        string       req;
        logic [26:0] v;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // reference model, written from the requirements: mode 0 unconfigured, 1 configured, 2 D3, 3 power-down
    int m_mode = 0;
    bit m_bar = 0, m_st = 0, m_pen = 0, m_len = 0, m_men = 0, m_lev = 0, m_mev = 0;

    function automatic logic [26:0] observed();
        return {pme_req, phy_pd, core_en, tx_en, rx_en, led_off, uninit, pmc_rdata, wev_rdata};
    endfunction

    function automatic logic [26:0] model_out();
        bit low, wol, hard;
        low  = (m_mode == 0) || (m_mode == 3);
        wol  = m_pen && (m_len || m_men);
        hard = low && !wol;
        return {m_st && m_pen, hard, !hard, !low, !hard, low, (m_mode == 0) && !wol,
                m_st, 6'b0, m_pen, 6'b0, (m_mode >= 2) ? 2'b11 : 2'b00,
                m_mev, m_lev, m_men, m_len};
    endfunction

    task automatic model_update();
        bit n_st, n_pen, n_len, n_men, n_lev, n_mev, n_bar, d0;
        int n_mode;
        n_st = m_st; n_pen = m_pen; n_len = m_len; n_men = m_men; n_lev = m_lev; n_mev = m_mev;
        if (pmc_wr) begin
            n_pen = pmc_wdata[8];
            if (pmc_wdata[15]) n_st = 0;
        end
        if (wev_wr) begin
            n_len = wev_wdata[0];
            n_men = wev_wdata[1];
            if (wev_wdata[2]) n_lev = 0;
            if (wev_wdata[3]) n_mev = 0;
        end
        if (link_chg && m_len) begin n_lev = 1; n_len = 0; n_st = 1; end
        if (magic_pkt && m_men) begin n_mev = 1; n_st = 1; end
        n_bar = m_bar; n_mode = m_mode;
        d0 = (m_mode <= 1);
        if (bar_wr) n_bar = (bar_field != 0);
        if (pmc_wr && pmc_wdata[1:0] == 2'b11 && d0) n_mode = 2;
        else if (pmc_wr && pmc_wdata[1:0] == 2'b00 && !d0) begin n_mode = 0; n_bar = 0; end
        else if (m_mode == 2 && !pme_line) n_mode = 3;
        if (n_mode <= 1) n_mode = (force_cfg || n_bar) ? 1 : 0;
        m_st = n_st; m_pen = n_pen; m_len = n_len; m_men = n_men; m_lev = n_lev; m_mev = n_mev;
        m_bar = n_bar; m_mode = n_mode;
    endtask

    // driver: inputs already set at a falling edge; one rising edge, then queue the expectation
    task automatic step(input string req);
        exp_t e;
        @(posedge clk);
        model_update();
        e.req = req;
        e.v   = model_out();
        exp_q.push_back(e);
        @(negedge clk);
        pmc_wr = 0; wev_wr = 0; bar_wr = 0; link_chg = 0; magic_pkt = 0;
    endtask

    task automatic wr_pmc(input logic [15:0] d, input string req);
        pmc_wr = 1; pmc_wdata = d; step(req);
    endtask
    task automatic wr_wev(input logic [3:0] d, input string req);
        wev_wr = 1; wev_wdata = d; step(req);
    endtask
    task automatic wr_bar(input logic [BAR_W-1:0] d, input string req);
        bar_wr = 1; bar_field = d; step(req);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (observed() !== e.v) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b", e.req, observed(), e.v);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        n_checks++;
        if (observed() !== model_out()) begin
            n_fail++;
            $display("FAIL R1: got %b expected %b", observed(), model_out());
        end
        step("R1 idle after reset");
        wr_bar(20'h00040, "R2 nonzero field configures");
        wr_bar(20'h00000, "R2 zero field unconfigures");
        force_cfg = 1; step("R3 strap forces configured");
        wr_bar(20'h00000, "R3 zero write under strap");
        force_cfg = 0; step("R3 strap released");
        wr_bar(20'h80001, "R2 configure again");
        wr_pmc(16'h0001, "R11 state code 01 ignored");
        wr_pmc(16'h0002, "R11 state code 10 ignored");
        link_chg = 1; step("R5 link change with enable clear");
        wr_wev(4'b0010, "R4 magic enable");
        magic_pkt = 1; step("R4 magic wake");
        wr_pmc(16'h0100, "R6 pme enable raises request");
        wr_pmc(16'h0000, "R6 pme enable cleared, status kept");
        wr_wev(4'b0010, "R7 zero at W1C keeps magic event");
        wr_wev(4'b1010, "R7 W1C clears magic event");
        wr_pmc(16'h0000, "R7 zero at status keeps it");
        wr_pmc(16'h8000, "R7 W1C clears status");
        wr_wev(4'b0001, "R5 link enable");
        link_chg = 1; step("R5 link wake");
        link_chg = 1; step("R5 second link change ignored");
        wr_wev(4'b0100, "R7 clear link event");
        wr_pmc(16'h8000, "R7 clear status");
        pme_line = 1; wr_pmc(16'h0003, "R8 enter D3");
        step("R8 D3 holds with PME line asserted");
        pme_line = 0; step("R8 power-down on PME release");
        step("R8 power-down holds");
        wr_pmc(16'h0003, "R8 D3 write in power-down ignored");
        wr_pmc(16'h0000, "R9 return to D0 drops configuration");
        wr_wev(4'b0010, "R10 arm magic enable");
        wr_pmc(16'h0100, "R10 armed in unconfigured mode");
        wr_pmc(16'h0103, "R10 armed D3 entry");
        step("R10 armed power-down keeps PHY up");
        magic_pkt = 1; step("R4 magic wake in power-down");
        step("R6 request held");
        pme_line = 1; wr_pmc(16'h8000, "R9 leave power-down, clear status");
        wr_bar(20'h00100, "R2 configure after return");
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule